// File: doc/BRIEF.md
# Burst Mode Handshake Controller

This block sits beside a bus sequencer and settles, for every bus transaction, whether the data phase is a single beat or a fixed-length burst. When a transaction starts, the controller looks at two configuration bits and at whether the transaction can be bursted. If bursting is allowed, it pulls an active-low burst request low for the whole address phase. External logic may answer with an active-low acknowledge. The ready strobe, also active low, closes the first beat. The burst decision is taken in that ready clock.

An acknowledge counts if it is low in the ready clock itself. It also counts if it went low in an earlier clock and stayed low until ready. If the acknowledge is released before ready, the early answer is cancelled. A separate DRAM-burst-enable bit bypasses the acknowledge completely: the request is still raised, but a flag marks it as coming from the internal DRAM path, and the transfer becomes a burst whatever the acknowledge does. Once a burst is selected, the controller raises a burst flag and counts beats on each ready until the fixed burst length is reached.

The controller is built around four states:
- ST_IDLE: no transaction.
- ST_ADDR: address phase, with no acknowledge seen.
- ST_ACKED: address phase, with an early acknowledge held low.
- ST_BURST: the remaining beats of a burst.

The transitions are:
- T_START: ST_IDLE to ST_ADDR, on a transaction start.
- T_ACK_EARLY: ST_ADDR to ST_ACKED, when the acknowledge is low without ready.
- T_ACK_DROP: ST_ACKED to ST_ADDR, when the acknowledge is released before ready.
- T_SINGLE: ST_ADDR or ST_ACKED to ST_IDLE, on ready with no burst decided.
- T_BURST_GO: ST_ADDR or ST_ACKED to ST_BURST, on ready with a burst decided.
- T_LAST_BEAT: ST_BURST to ST_IDLE, on ready for the final beat.

Top module: `burst_handshake_ctrl`

## Requirements
- R1: One cycle after a start is accepted in ST_IDLE, the request output `req_n_o` goes low exactly when `txn_burstable_i` is 1 and at least one of `burst_en_i` and `dram_burst_en_i` is 1. It stays low until the clock edge that samples `rdy_n_i` low, and is high (1) in every other state.
- R2: In the ready clock (`rdy_n_i`=0 during the address phase), if the request is active and `ack_n_i`=0, then on the next cycle `burst_sel_o`=1 and `beat_cnt_o`=1.
- R3: An acknowledge driven low before ready and held low until the ready clock selects a burst. An acknowledge that was low earlier but is high (1) in the ready clock selects a single beat.
- R4: If `dram_burst_en_i`=1 and the transaction is burstable, a burst is selected at the first ready even when `ack_n_i` stays 1 throughout.
- R5: `req_src_dram_o` is 1 exactly while the request is active and the transaction was started with `dram_burst_en_i`=1. In that case the request is still driven low.
- R6: A burst is `BEATS` beats long (default 4). `beat_cnt_o` increases by 1 on each ready while `burst_sel_o`=1, and holds when ready is high. On the ready that completes beat `BEATS`, `burst_sel_o` returns to 0 and `beat_cnt_o` to 0 on the next cycle.
- R7: A single-beat decision leaves `burst_sel_o`=0 and `beat_cnt_o`=0, and the controller is idle on the cycle after the ready.
- R8: `txn_start_i` has no effect outside ST_IDLE. A start asserted during a burst produces no request after the burst ends.
- R9: A synchronous active-high `rst` forces `req_n_o`=1, `req_src_dram_o`=0, `burst_sel_o`=0 and `beat_cnt_o`=0 on the next cycle, including in the middle of a burst.
- R10: A transaction started with `txn_burstable_i`=0 raises no request and completes as a single beat, whatever the values of `ack_n_i`, `burst_en_i` and `dram_burst_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_en_i | input | 1 | Burst mode enable control bit |
| dram_burst_en_i | input | 1 | DRAM burst enable: forces a burst without acknowledge |
| txn_start_i | input | 1 | Start of a bus transaction (accepted only in idle) |
| txn_burstable_i | input | 1 | The starting transaction may be bursted |
| ack_n_i | input | 1 | Burst acknowledge from external logic, active low |
| rdy_n_i | input | 1 | Beat ready strobe, active low |
| req_n_o | output | 1 | Burst request, active low |
| req_src_dram_o | output | 1 | Request is driven by the internal DRAM path |
| burst_sel_o | output | 1 | Burst mode selected for the current transaction |
| beat_cnt_o | output | CNT_W | Beats completed in the current burst |

## Verification
The bench builds the controller with `BEATS`=4, which gives a 2-bit counter, so the wrap from the last beat back to zero is exercised on every burst.

The bench sweeps all eight combinations of the two enable bits and the burstable flag. Each combination is crossed with five acknowledge patterns:
- never asserted;
- asserted only in the ready clock;
- asserted early and held;
- asserted early and then dropped;
- asserted early, dropped, then asserted again at ready.

Each of these runs with zero to two wait cycles before ready. This covers every transition out of ST_ADDR and ST_ACKED.

Inside each burst, idle gaps and a start pulse that must be ignored are placed between beats. A reset is also applied in the middle of a burst.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_ACKED = 2'd2,
        ST_BURST = 2'd3
    } bhc_state_e;

    function automatic logic in_addr_phase(input bhc_state_e st);
        return (st == ST_ADDR) || (st == ST_ACKED);
    endfunction

endpackage

// File: rtl/bhc_req_gen.sv
module bhc_req_gen (
    input  logic clk,
    input  logic rst,
    input  logic start_take,
    input  logic burst_en,
    input  logic dram_en,
    input  logic burstable,
    output logic req_q,
    output logic dram_q
);

    logic req_d;
    logic dram_d;

    always_comb begin
        req_d  = req_q;
        dram_d = dram_q;
        if (start_take) begin
            req_d  = burstable && (burst_en || dram_en);
            dram_d = burstable && dram_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            dram_q <= 1'b0;
        end else begin
            req_q  <= req_d;
            dram_q <= dram_d;
        end
    end

endmodule

// File: rtl/bhc_beat_ctr.sv
module bhc_beat_ctr #(
    parameter int BEATS = 4,
    localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_d;
    end

    assign last = (cnt == LAST_VAL);

endmodule

// File: rtl/bhc_fsm.sv
module bhc_fsm
    import bhc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       txn_start,
    input  logic       ack_n,
    input  logic       rdy_n,
    input  logic       req_q,
    input  logic       dram_q,
    input  logic       beat_last,
    output bhc_state_e state,
    output logic       start_take,
    output logic       ctr_inc,
    output logic       ctr_clr
);

    bhc_state_e state_d;
    logic       burst_go;
    logic       ready;
    logic       ack_low;

    assign ready    = !rdy_n;
    assign ack_low  = !ack_n;
    // Decision in the ready clock: the DRAM path overrides the acknowledge
    assign burst_go = dram_q || (req_q && ack_low);

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (txn_start)
                    state_d = ST_ADDR;                  // T_START
            end
            ST_ADDR: begin
                if (ready)
                    state_d = burst_go ? ST_BURST       // T_BURST_GO
                                       : ST_IDLE;       // T_SINGLE
                else if (req_q && ack_low)
                    state_d = ST_ACKED;                 // T_ACK_EARLY
            end
            ST_ACKED: begin
                if (ready)
                    state_d = burst_go ? ST_BURST       // T_BURST_GO
                                       : ST_IDLE;       // T_SINGLE
                else if (!ack_low)
                    state_d = ST_ADDR;                  // T_ACK_DROP
            end
            ST_BURST: begin
                if (ready && beat_last)
                    state_d = ST_IDLE;                  // T_LAST_BEAT
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Control outputs
    always_comb begin
        start_take = 1'b0;
        ctr_inc    = 1'b0;
        ctr_clr    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                start_take = txn_start;
                ctr_clr    = 1'b1;
            end
            ST_ADDR, ST_ACKED: begin
                ctr_inc = ready && burst_go;
                ctr_clr = ready && !burst_go;
            end
            ST_BURST: begin
                ctr_inc = ready && !beat_last;
                ctr_clr = ready && beat_last;
            end
            default: ctr_clr = 1'b1;
        endcase
    end

endmodule

// File: rtl/burst_handshake_ctrl.sv
module burst_handshake_ctrl
    import bhc_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             burst_en_i,
    input  logic             dram_burst_en_i,
    input  logic             txn_start_i,
    input  logic             txn_burstable_i,
    input  logic             ack_n_i,
    input  logic             rdy_n_i,
    output logic             req_n_o,
    output logic             req_src_dram_o,
    output logic             burst_sel_o,
    output logic [CNT_W-1:0] beat_cnt_o
);

    bhc_state_e state;
    logic       start_take;
    logic       ctr_inc;
    logic       ctr_clr;
    logic       req_q;
    logic       dram_q;
    logic       beat_last;

    bhc_req_gen u_req (
        .clk       (clk),
        .rst       (rst),
        .start_take(start_take),
        .burst_en  (burst_en_i),
        .dram_en   (dram_burst_en_i),
        .burstable (txn_burstable_i),
        .req_q     (req_q),
        .dram_q    (dram_q)
    );

    bhc_beat_ctr #(.BEATS(BEATS)) u_ctr (
        .clk (clk),
        .rst (rst),
        .clr (ctr_clr),
        .inc (ctr_inc),
        .cnt (beat_cnt_o),
        .last(beat_last)
    );

    bhc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .txn_start (txn_start_i),
        .ack_n     (ack_n_i),
        .rdy_n     (rdy_n_i),
        .req_q     (req_q),
        .dram_q    (dram_q),
        .beat_last (beat_last),
        .state     (state),
        .start_take(start_take),
        .ctr_inc   (ctr_inc),
        .ctr_clr   (ctr_clr)
    );

    // Outputs decoded from state and latched request flags
    always_comb begin
        req_n_o        = 1'b1;
        req_src_dram_o = 1'b0;
        burst_sel_o    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ADDR, ST_ACKED: begin
                req_n_o        = !req_q;
                req_src_dram_o = req_q && dram_q;
            end
            ST_BURST: burst_sel_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bhc_checker.sv
module bhc_checker #(
    parameter int BEATS = 4,
    localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             burst_en_i,
    input logic             dram_burst_en_i,
    input logic             txn_start_i,
    input logic             txn_burstable_i,
    input logic             ack_n_i,
    input logic             rdy_n_i,
    input logic             req_n_o,
    input logic             req_src_dram_o,
    input logic             burst_sel_o,
    input logic [CNT_W-1:0] beat_cnt_o
);

    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(BEATS - 1);

    p_req_needs_enable_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(req_n_o) |-> $past(txn_start_i && txn_burstable_i && (burst_en_i || dram_burst_en_i)));

    p_req_held_r1: assert property (@(posedge clk) disable iff (rst)
        (!req_n_o && rdy_n_i) |=> !req_n_o);

    p_req_release_r1: assert property (@(posedge clk) disable iff (rst)
        (!req_n_o && !rdy_n_i) |=> req_n_o);

    p_ack_burst_r2: assert property (@(posedge clk) disable iff (rst)
        (!req_n_o && !rdy_n_i && !ack_n_i) |=> (burst_sel_o && beat_cnt_o == CNT_W'(1)));

    p_late_release_single_r3: assert property (@(posedge clk) disable iff (rst)
        (!req_n_o && !rdy_n_i && ack_n_i && !req_src_dram_o) |=> (!burst_sel_o && beat_cnt_o == '0));

    p_dram_force_r4: assert property (@(posedge clk) disable iff (rst)
        (!req_n_o && !rdy_n_i && req_src_dram_o) |=> burst_sel_o);

    p_src_with_req_r5: assert property (@(posedge clk) disable iff (rst)
        req_src_dram_o |-> !req_n_o);

    p_beat_step_r6: assert property (@(posedge clk) disable iff (rst)
        (burst_sel_o && !rdy_n_i && beat_cnt_o != LAST_VAL) |=>
            (burst_sel_o && beat_cnt_o == $past(beat_cnt_o) + 1'b1));

    p_beat_end_r6: assert property (@(posedge clk) disable iff (rst)
        (burst_sel_o && !rdy_n_i && beat_cnt_o == LAST_VAL) |=> (!burst_sel_o && beat_cnt_o == '0));

    p_beat_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (burst_sel_o && rdy_n_i) |=> (burst_sel_o && $stable(beat_cnt_o)));

    p_no_req_in_burst_r8: assert property (@(posedge clk) disable iff (rst)
        burst_sel_o |-> (req_n_o && !req_src_dram_o));

endmodule

bind burst_handshake_ctrl bhc_checker #(.BEATS(BEATS)) u_bhc_chk (
    .clk            (clk),
    .rst            (rst),
    .burst_en_i     (burst_en_i),
    .dram_burst_en_i(dram_burst_en_i),
    .txn_start_i    (txn_start_i),
    .txn_burstable_i(txn_burstable_i),
    .ack_n_i        (ack_n_i),
    .rdy_n_i        (rdy_n_i),
    .req_n_o        (req_n_o),
    .req_src_dram_o (req_src_dram_o),
    .burst_sel_o    (burst_sel_o),
    .beat_cnt_o     (beat_cnt_o)
);

// File: tb/tb_burst_handshake_ctrl.sv
`timescale 1ns/1ps
module tb_burst_handshake_ctrl;

    localparam int BEATS = 4;
    localparam int CNT_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             burst_en_i = 1'b0;
    logic             dram_burst_en_i = 1'b0;
    logic             txn_start_i = 1'b0;
    logic             txn_burstable_i = 1'b0;
    logic             ack_n_i = 1'b1;
    logic             rdy_n_i = 1'b1;
    logic             req_n_o;
    logic             req_src_dram_o;
    logic             burst_sel_o;
    logic [CNT_W-1:0] beat_cnt_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_handshake_ctrl #(.BEATS(BEATS)) dut (
        .clk            (clk),
        .rst            (rst),
        .burst_en_i     (burst_en_i),
        .dram_burst_en_i(dram_burst_en_i),
        .txn_start_i    (txn_start_i),
        .txn_burstable_i(txn_burstable_i),
        .ack_n_i        (ack_n_i),
        .rdy_n_i        (rdy_n_i),
        .req_n_o        (req_n_o),
        .req_src_dram_o (req_src_dram_o),
        .burst_sel_o    (burst_sel_o),
        .beat_cnt_o     (beat_cnt_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // mode 0 none, 1 ready clock only, 2 early held, 3 early then dropped,
    // 4 early, dropped, low again at ready
    function automatic logic ack_at(input int mode, input int k, input int waits);
        case (mode)
            0: return 1'b1;
            1: return (k == waits) ? 1'b0 : 1'b1;
            2: return 1'b0;
            3: return (k >= waits - 1 && waits > 0) ? 1'b1 : 1'b0;
            default: return (k == waits) ? 1'b0 : ((k == waits - 1) ? 1'b1 : 1'b0);
        endcase
    endfunction

    task automatic run_txn(input bit be, input bit de, input bit bl, input int mode, input int waits);
        bit exp_req;
        bit exp_burst;
        bit ack_ready;
        string tag;
        exp_req   = bl && (be || de);
        ack_ready = !ack_at(mode, waits, waits);
        exp_burst = exp_req && (de || ack_ready);
        if (mode == 0) tag = "R7";
        else if (mode == 1) tag = "R2";
        else tag = "R3";
        if (de && bl) tag = "R4";
        if (!bl) tag = "R10";

        burst_en_i = be; dram_burst_en_i = de; txn_burstable_i = bl;
        txn_start_i = 1'b1;
        step();
        txn_start_i = 1'b0;
        check(bl ? "R1 req" : "R10 req", req_n_o, !exp_req);
        check("R5 src", req_src_dram_o, bl && de);
        for (int k = 0; k < waits; k++) begin
            ack_n_i = ack_at(mode, k, waits);
            step();
            check("R1 req held", req_n_o, !exp_req);
        end
        ack_n_i = ack_at(mode, waits, waits);
        rdy_n_i = 1'b0;
        step();
        rdy_n_i = 1'b1;
        ack_n_i = 1'b1;
        check({tag, " decision"}, burst_sel_o, exp_burst);
        check({tag, " count"}, beat_cnt_o, exp_burst ? 1 : 0);
        check("R1 req released", req_n_o, 1);
        if (exp_burst) begin
            for (int b = 2; b <= BEATS; b++) begin
                // gap cycle; a start here must be ignored (R8)
                txn_start_i = (b == 3);
                txn_burstable_i = 1'b1;
                step();
                txn_start_i = 1'b0;
                check("R6 hold", beat_cnt_o, b - 1);
                check("R8 busy", req_n_o, 1);
                rdy_n_i = 1'b0;
                step();
                rdy_n_i = 1'b1;
                check("R6 count", beat_cnt_o, (b == BEATS) ? 0 : b);
                check("R6 flag", burst_sel_o, (b == BEATS) ? 0 : 1);
            end
            step();
            check("R8 ignored start", req_n_o, 1);
            check("R8 idle", burst_sel_o, 0);
        end else begin
            check("R7 idle", burst_sel_o, 0);
        end
    endtask

    initial begin
        @(negedge clk);
        burst_en_i = 1'b1; dram_burst_en_i = 1'b1; txn_burstable_i = 1'b1;
        txn_start_i = 1'b1; ack_n_i = 1'b0; rdy_n_i = 1'b0;
        step(); step();
        check("R9 reset req", req_n_o, 1);
        check("R9 reset src", req_src_dram_o, 0);
        check("R9 reset flag", burst_sel_o, 0);
        check("R9 reset cnt", beat_cnt_o, 0);
        txn_start_i = 1'b0; ack_n_i = 1'b1; rdy_n_i = 1'b1;
        rst = 1'b0;
        step();

        for (int cfg = 0; cfg < 8; cfg++)
            for (int mode = 0; mode < 5; mode++)
                for (int w = 0; w < 3; w++)
                    run_txn(cfg[0], cfg[1], cfg[2], mode, w);

        // reset in the middle of a burst
        burst_en_i = 1'b1; dram_burst_en_i = 1'b0; txn_burstable_i = 1'b1;
        txn_start_i = 1'b1;
        step();
        txn_start_i = 1'b0;
        ack_n_i = 1'b0; rdy_n_i = 1'b0;
        step();
        ack_n_i = 1'b1;
        step();
        check("R6 mid", beat_cnt_o, 2);
        rdy_n_i = 1'b1;
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R9 mid flag", burst_sel_o, 0);
        check("R9 mid cnt", beat_cnt_o, 0);
        check("R9 mid req", req_n_o, 1);
        step();
        check("R9 stays idle", burst_sel_o, 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule